// File: doc/BRIEF.md
# Byte-Addressable Data Memory with Selectable Byte Order

This block is a small synchronous data memory built from 8-bit storage cells. Cell addresses start at zero, and any cell can be reached in any order. One request port serves accesses of one, two, four or eight bytes. A value wider than a byte fills consecutive cells, and it is named by the address of its first cell.

A run-time byte-order input decides which end of a multi-byte value lands at the lowest address. In little-endian order the least significant byte goes there. In big-endian order the most significant byte goes there. Write data is taken from the low end of a 64-bit bus. Read data comes back on a 64-bit bus, right-justified and zero-extended, one clock after the request.

An access whose address is not a multiple of its size raises a misalignment flag. A misaligned write changes nothing. A misaligned read returns zero.

Top module: `endian_byte_ram`

## Requirements
- R1: Each address holds exactly one 8-bit value. A byte write (size code 00) followed by a byte read at the same address returns that byte. Writes to other addresses leave it unchanged.
- R2: With `big_endian_i` low (little-endian), a multi-byte write stores bits [7:0] of the value at the named address and bits [8k+7:8k] at address plus k.
- R3: With `big_endian_i` high (big-endian), a write of N bytes stores the most significant byte at the named address and bits [8k+7:8k] at address plus N-1-k.
- R4: The size code selects the access width: 00 is 1 byte, 01 is 2 bytes, 10 is 4 bytes and 11 is 8 bytes. An aligned read in the same byte order as the write returns the written value.
- R5: Read data appears on `rdata_o` on the clock edge after the read request, in the low 8N bits, with all higher bits zero.
- R6: `rdata_o` keeps its value across write requests and idle cycles.
- R7: `misalign_o` is registered on the edge after each request. It is 1 exactly when the address is not a multiple of the access size, and it is 0 after a cycle with no request.
- R8: A misaligned write modifies no memory cell.
- R9: A misaligned read returns zero on `rdata_o`.
- R10: A value written in one byte order and read back at the same size in the other order comes back byte-reversed. For example, a 4-byte 17 written big-endian reads little-endian as 0x11000000.
- R11: A write of N bytes changes only the N cells it names. Neighbouring cells keep their contents.
- R12: While `rst_n` is low, `rdata_o` and `misalign_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the first cell |
| size_i | input | 2 | Access size code (00/01/10/11 = 1/2/4/8 bytes) |
| big_endian_i | input | 1 | 1 = most significant byte at lowest address |
| wdata_i | input | 64 | Write value, right-justified |
| rdata_o | output | 64 | Read value, right-justified and zero-extended |
| misalign_o | output | 1 | Previous request was misaligned |

## Verification
The bench builds the block with the default `ADDR_W` of 8, which gives a 256-byte array. With that depth the bench can write the top cells (for example address 255 and a word at 252) as well as address zero, so the lane address arithmetic is exercised at both ends of the array. The 8-byte lane width is fixed by the 2-bit size code, so every size and every low-address misalignment pattern is covered at this one setting.

// File: rtl/ebm_pkg.sv
package ebm_pkg;

  localparam int LANES  = 8;
  localparam int WORD_W = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } acc_size_e;

  typedef logic [LANES-1:0][7:0] lane_bytes_t;

  function automatic int nbytes(acc_size_e s);
    return 1 << int'(s);
  endfunction

endpackage

// File: rtl/ebm_align_check.sv
module ebm_align_check
  import ebm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  acc_size_e         size_i,
  output logic              misaligned_o
);

  logic [2:0] low_mask;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: low_mask = 3'b000;
      SZ_HALF: low_mask = 3'b001;
      SZ_WORD: low_mask = 3'b011;
      default: low_mask = 3'b111;
    endcase
    misaligned_o = |(addr_i[2:0] & low_mask);
  end

endmodule

// File: rtl/ebm_write_steer.sv
module ebm_write_steer
  import ebm_pkg::*;
(
  input  logic [WORD_W-1:0] wdata_i,
  input  acc_size_e         size_i,
  input  logic              big_endian_i,
  output lane_bytes_t       lane_data_o,
  output logic [LANES-1:0]  lane_en_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      int n;
      int src;
      n   = nbytes(size_i);
      src = 0;
      lane_en_o[g]   = (g < n);
      lane_data_o[g] = 8'h00;
      if (g < n) begin
        src = big_endian_i ? (n - 1 - g) : g;
        lane_data_o[g] = wdata_i[src*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/ebm_read_gather.sv
module ebm_read_gather
  import ebm_pkg::*;
(
  input  lane_bytes_t       lane_q_i,
  input  acc_size_e         size_i,
  input  logic              big_endian_i,
  output logic [WORD_W-1:0] value_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_byte
    always_comb begin
      int n;
      int src;
      n   = nbytes(size_i);
      src = 0;
      value_o[g*8 +: 8] = 8'h00;
      if (g < n) begin
        src = big_endian_i ? (n - 1 - g) : g;
        value_o[g*8 +: 8] = lane_q_i[src];
      end
    end
  end

endmodule

// File: rtl/ebm_byte_array.sv
module ebm_byte_array
  import ebm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LANES-1:0]  lane_en_i,
  input  lane_bytes_t       lane_data_i,
  output lane_bytes_t       lane_q_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        cells [DEPTH];
  logic [ADDR_W-1:0] lane_addr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_addr
    always_comb begin
      lane_addr[g] = base_i + ADDR_W'(g);
      lane_q_o[g]  = cells[lane_addr[g]];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_en_i[i]) cells[lane_addr[i]] <= lane_data_i[i];
      end
    end
  end

endmodule

// File: rtl/endian_byte_ram.sv
module endian_byte_ram
  import ebm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              big_endian_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  output logic              misalign_o
);

  acc_size_e         size_e;
  logic              misaligned;
  lane_bytes_t       lane_data;
  logic [LANES-1:0]  lane_en;
  lane_bytes_t       lane_q;
  logic [WORD_W-1:0] gathered;
  logic              write_go;
  logic              read_go;

  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              mis_q, mis_d;

  assign size_e = acc_size_e'(size_i);

  ebm_align_check #(.ADDR_W(ADDR_W)) u_align (
    .addr_i       (addr_i),
    .size_i       (size_e),
    .misaligned_o (misaligned)
  );

  ebm_write_steer u_steer (
    .wdata_i      (wdata_i),
    .size_i       (size_e),
    .big_endian_i (big_endian_i),
    .lane_data_o  (lane_data),
    .lane_en_o    (lane_en)
  );

  ebm_byte_array #(.ADDR_W(ADDR_W)) u_array (
    .clk         (clk),
    .wr_en_i     (write_go),
    .base_i      (addr_i),
    .lane_en_i   (lane_en),
    .lane_data_i (lane_data),
    .lane_q_o    (lane_q)
  );

  ebm_read_gather u_gather (
    .lane_q_i     (lane_q),
    .size_i       (size_e),
    .big_endian_i (big_endian_i),
    .value_o      (gathered)
  );

  always_comb begin
    write_go = req_i & we_i & ~misaligned;
    read_go  = req_i & ~we_i;
    rdata_d  = rdata_q;
    if (read_go) rdata_d = misaligned ? '0 : gathered;
    mis_d = req_i & misaligned;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      mis_q   <= 1'b0;
    end else begin
      if (read_go) rdata_q <= rdata_d;
      mis_q <= mis_d;
    end
  end

  assign rdata_o    = rdata_q;
  assign misalign_o = mis_q;

endmodule

// File: rtl/ebm_checker.sv
module ebm_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic [63:0]       rdata_o,
  input logic              misalign_o
);

  a_r7_odd_half_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && size_i == 2'b01 && addr_i[0]) |=> misalign_o);

  a_r7_byte_never_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && size_i == 2'b00) |=> !misalign_o);

  a_r7_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !misalign_o);

  a_r6_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_i || we_i) |=> $stable(rdata_o));

  a_r5_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && size_i == 2'b00) |=> (rdata_o[63:8] == 56'd0));

  a_r5_half_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && size_i == 2'b01) |=> (rdata_o[63:16] == 48'd0));

  a_r9_misread_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !we_i && size_i == 2'b11 && addr_i[2:0] != 3'b000) |=> (rdata_o == 64'd0));

endmodule

bind endian_byte_ram ebm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .size_i     (size_i),
  .rdata_o    (rdata_o),
  .misalign_o (misalign_o)
);

// File: tb/endian_byte_ram_test.sv
module endian_byte_ram_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;

  logic              clk;
  logic              rst_n;
  logic              req_i;
  logic              we_i;
  logic [ADDR_W-1:0] addr_i;
  logic [1:0]        size_i;
  logic              big_endian_i;
  logic [63:0]       wdata_i;
  logic [63:0]       rdata_o;
  logic              misalign_o;

  int checks = 0;
  int fails  = 0;

  endian_byte_ram #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .big_endian_i(big_endian_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .misalign_o(misalign_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic op(input logic w, input int a, input logic [1:0] sz, input logic be,
                    input logic [63:0] d, output logic [63:0] rd, output logic mis);
    req_i = 1'b1; we_i = w; addr_i = ADDR_W'(a); size_i = sz; big_endian_i = be; wdata_i = d;
    @(negedge clk);
    rd = rdata_o; mis = misalign_o;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wr(input int a, input logic [1:0] sz, input logic be, input logic [63:0] d);
    logic [63:0] rd; logic mis;
    op(1'b1, a, sz, be, d, rd, mis);
  endtask

  task automatic rdv(input int a, input logic [1:0] sz, input logic be, output logic [63:0] v);
    logic mis;
    op(1'b0, a, sz, be, 64'd0, v, mis);
  endtask

  task automatic t_reset;
    check("R12 rdata at reset", rdata_o, 64'd0);
    check("R12 misalign at reset", {63'd0, misalign_o}, 64'd0);
  endtask

  task automatic t_bytes;
    logic [63:0] v;
    wr(0, 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FF5A);
    wr(1, 2'b00, 1'b0, 64'h00000000000000C3);
    wr(255, 2'b00, 1'b1, 64'h0000000000000077);
    rdv(0, 2'b00, 1'b0, v);   check("R1 byte at 0", v, 64'h5A);
    rdv(1, 2'b00, 1'b1, v);   check("R1 byte at 1", v, 64'hC3);
    rdv(255, 2'b00, 1'b0, v); check("R1 byte at top address", v, 64'h77);
  endtask

  task automatic t_little;
    logic [63:0] v;
    wr(16, 2'b11, 1'b0, 64'h0807060504030201);
    for (int k = 0; k < 8; k++) begin
      rdv(16 + k, 2'b00, 1'b0, v);
      check("R2 little-endian byte placement", v, 64'(k + 1));
    end
    rdv(16, 2'b11, 1'b0, v); check("R4 dword roundtrip LE", v, 64'h0807060504030201);
  endtask

  task automatic t_big;
    logic [63:0] v;
    wr(32, 2'b11, 1'b1, 64'h0807060504030201);
    for (int k = 0; k < 8; k++) begin
      rdv(32 + k, 2'b00, 1'b1, v);
      check("R3 big-endian byte placement", v, 64'(8 - k));
    end
    wr(40, 2'b01, 1'b1, 64'h000000000000BEEF);
    rdv(40, 2'b00, 1'b0, v); check("R3 half MS byte first", v, 64'hBE);
    rdv(40, 2'b01, 1'b1, v); check("R4 half roundtrip BE", v, 64'hBEEF);
  endtask

  task automatic t_sizes;
    logic [63:0] v;
    wr(2, 2'b01, 1'b0, 64'hDEAD_BEEF_CAFE_1234);
    rdv(2, 2'b01, 1'b0, v); check("R5 half right-justified zero-extended", v, 64'h1234);
    wr(252, 2'b10, 1'b0, 64'hFFFF_FFFF_A1B2_C3D4);
    rdv(252, 2'b10, 1'b0, v); check("R4 word at top roundtrip", v, 64'hA1B2C3D4);
    rdv(252, 2'b00, 1'b0, v); check("R5 byte zero-extended", v, 64'hD4);
  endtask

  task automatic t_hold;
    logic [63:0] v;
    rdv(2, 2'b01, 1'b0, v);
    wr(100, 2'b10, 1'b0, 64'h0000_0000_5555_5555);
    check("R6 rdata held over write", rdata_o, 64'h1234);
    @(negedge clk);
    check("R6 rdata held over idle", rdata_o, 64'h1234);
  endtask

  task automatic t_partial;
    logic [63:0] v;
    wr(48, 2'b11, 1'b0, 64'h1122334455667788);
    wr(50, 2'b00, 1'b0, 64'h00000000000000AA);
    rdv(48, 2'b11, 1'b0, v); check("R11 byte write leaves neighbours", v, 64'h1122334455AA7788);
    wr(52, 2'b01, 1'b1, 64'h000000000000BBCC);
    rdv(48, 2'b11, 1'b0, v); check("R11 half write leaves neighbours", v, 64'h1122CCBB55AA7788);
  endtask

  task automatic t_misalign;
    logic [63:0] v; logic mis;
    wr(56, 2'b11, 1'b0, 64'h0F0E0D0C0B0A0908);
    op(1'b1, 57, 2'b01, 1'b0, 64'hFFFF, v, mis);
    check("R7 odd half write flags", {63'd0, mis}, 64'd1);
    op(1'b0, 56, 2'b11, 1'b0, 64'd0, v, mis);
    check("R8 misaligned write changed nothing", v, 64'h0F0E0D0C0B0A0908);
    check("R7 aligned dword no flag", {63'd0, mis}, 64'd0);
    op(1'b1, 58, 2'b10, 1'b1, 64'hFFFFFFFF, v, mis);
    check("R7 word at 58 flags", {63'd0, mis}, 64'd1);
    op(1'b0, 60, 2'b11, 1'b0, 64'd0, v, mis);
    check("R9 misaligned read returns zero", v, 64'd0);
    check("R7 dword at 60 flags", {63'd0, mis}, 64'd1);
    op(1'b0, 59, 2'b00, 1'b0, 64'd0, v, mis);
    check("R7 byte at odd address no flag", {63'd0, mis}, 64'd0);
    rdv(56, 2'b11, 1'b0, v); check("R8 memory intact after misaligned word", v, 64'h0F0E0D0C0B0A0908);
    op(1'b0, 61, 2'b01, 1'b0, 64'd0, v, mis);
    @(negedge clk);
    check("R7 flag clears after idle", {63'd0, misalign_o}, 64'd0);
  endtask

  task automatic t_cross;
    logic [63:0] v;
    wr(8, 2'b10, 1'b1, 64'd17);
    rdv(8, 2'b10, 1'b0, v); check("R10 BE word 17 read LE", v, 64'h11000000);
    wr(24, 2'b11, 1'b0, 64'h0123456789ABCDEF);
    rdv(24, 2'b11, 1'b1, v); check("R10 LE dword read BE", v, 64'hEFCDAB8967452301);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = 1'b0; we_i = 1'b0; addr_i = '0; size_i = 2'b00;
    big_endian_i = 1'b0; wdata_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_bytes();
    t_little();
    t_big();
    t_sizes();
    t_hold();
    t_partial();
    t_misalign();
    t_cross();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule